// File: doc/BRIEF.md
# Segmented-Window Reseeding Pattern Controller

This block is a built-in pattern source for scan-based testing. It takes compressed seeds one at a time from a seed stream and loads each one into a linear feedback shift register. It then expands the seed into a window of test vectors, which it shifts in parallel into a set of scan chains. After each vector it gives one capture strobe. The window is divided into equal segments. Only the leading segments that carry useful vectors are generated, so the redundant tail of every window is never applied.

Seeds arrive ordered from the most useful segments to the fewest. Each entry carries a seed word, a one-bit step flag and an end-of-stream flag. A down counter holds the segment budget. It starts at the full segment count when a run begins. When an accepted seed has its step flag set, the counter drops by one. A per-window segment counter is loaded from the budget whenever a seed is accepted. When the window ends, the controller requests the next seed. After the window of the final seed it raises done.

Top module: `seg_reseed_ctrl`

## Requirements
- R1: After reset, seed_req, done, scan_en and capture are all low. A start pulse in the idle state makes seed_req high from the next cycle.
- R2: seed_req stays high until a clock edge samples seed_valid high. seed_valid has no effect while seed_req is low, both during a window and while done is high.
- R3: The cycle after a seed is accepted, the register holds the seed word and scan_in shows its CHAINS low-order bits. The register then advances once per shift cycle as next = {s[W-2:0], ^(s & TAPS)}, and scan_in always shows the current low-order bits.
- R4: Every vector takes exactly CHAIN_LEN consecutive cycles with scan_en high, followed by exactly one cycle with capture high and scan_en low.
- R5: The segment budget is set to SEGS at each start. Each accepted seed with step flag 1 lowers the budget by one, and step flag 0 keeps it. The budget never drops below one, so a step at one is ignored.
- R6: The window of an accepted seed produces exactly k·VPS vectors, where k is the budget after that seed's step flag has been applied.
- R7: When a window ends, seed_req rises in the next cycle if the seed was not marked last. If it was marked last, done rises instead and stays high until start, which requests a new seed with the budget restored to SEGS.
- R8: scan_en and capture are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a run from idle or done |
| seed_valid | input | 1 | Seed stream entry present |
| seed_data | input | LFSR_W | Seed word |
| seed_step | input | 1 | Budget step flag: 1 lowers the segment budget by one |
| seed_last | input | 1 | Entry is the final seed of the stream |
| seed_req | output | 1 | Controller is ready to take a seed |
| scan_in | output | CHAINS | Parallel scan-in bits, one per chain |
| scan_en | output | 1 | High during shift cycles |
| capture | output | 1 | One-cycle capture strobe after each vector |
| done | output | 1 | Final window has completed |

## Verification
All outputs are Moore outputs of registered state. seed_req follows a start or a window's closing capture after one edge. The first scan bits of a window appear one edge after the seed is taken, and every shift edge after that brings the next register state. The bench drives inputs at the falling edge and samples at the falling edge. It compares scan_in with its own register model from the first cycle after acceptance, and it counts shift runs and captures until seed_req or done shows up one edge after the final capture. The budget arithmetic is recomputed in the bench before each seed, so the vector count expected for each window is fixed before the window starts.

// File: rtl/srw_pkg.sv
package srw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_SHIFT,
    ST_CAPT,
    ST_DONE
  } ctrl_state_t;

  // Budget after applying one seed's step flag; floor at one segment.
  function automatic int unsigned budget_after(input int unsigned cur, input logic step);
    if (step && cur > 1) return cur - 1;
    return cur;
  endfunction

endpackage

// File: rtl/srw_lfsr.sv
module srw_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] seed,
  output logic [W-1:0] state
);

  function automatic logic [W-1:0] advance(input logic [W-1:0] s);
    return {s[W-2:0], ^(s & TAPS)};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)    state <= '0;
    else if (load) state <= seed;
    else if (step) state <= advance(state);
  end

endmodule

// File: rtl/srw_budget.sv
module srw_budget
  import srw_pkg::*;
#(
  parameter int SEGS  = 4,
  parameter int SEG_W = $clog2(SEGS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             take,
  input  logic             step,
  output logic [SEG_W-1:0] count,
  output logic [SEG_W-1:0] next_count
);

  always_comb begin
    next_count = count;
    if (take) next_count = SEG_W'(budget_after(int'(count), step));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    count <= SEG_W'(SEGS);
    else if (init) count <= SEG_W'(SEGS);
    else           count <= next_count;
  end

endmodule

// File: rtl/srw_window_seq.sv
module srw_window_seq #(
  parameter int CHAIN_LEN = 8,
  parameter int VPS       = 2,
  parameter int SEGS      = 4,
  parameter int SEG_W     = $clog2(SEGS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SEG_W-1:0] load_segs,
  input  logic             shifting,
  input  logic             capturing,
  output logic             bit_last,
  output logic             vec_last,
  output logic             win_last,
  output logic [SEG_W-1:0] seg_cnt
);

  localparam int BIT_W = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;
  localparam int VEC_W = (VPS > 1) ? $clog2(VPS) : 1;

  logic [BIT_W-1:0] bit_cnt;
  logic [VEC_W-1:0] vec_cnt;

  assign bit_last = (bit_cnt == BIT_W'(CHAIN_LEN - 1));
  assign vec_last = (vec_cnt == VEC_W'(VPS - 1));
  assign win_last = vec_last && (seg_cnt == SEG_W'(1));

  // Bit counter: one count per shift cycle.
  always_ff @(posedge clk) begin
    if (!rst_n)                bit_cnt <= '0;
    else if (load)             bit_cnt <= '0;
    else if (shifting)         bit_cnt <= bit_last ? '0 : bit_cnt + BIT_W'(1);
  end

  // Segment-vectors counter: one count per capture.
  always_ff @(posedge clk) begin
    if (!rst_n)                vec_cnt <= '0;
    else if (load)             vec_cnt <= '0;
    else if (capturing)        vec_cnt <= vec_last ? '0 : vec_cnt + VEC_W'(1);
  end

  // Segment counter: loaded from the budget, one down per finished segment.
  always_ff @(posedge clk) begin
    if (!rst_n)                        seg_cnt <= '0;
    else if (load)                     seg_cnt <= load_segs;
    else if (capturing && vec_last)    seg_cnt <= seg_cnt - SEG_W'(1);
  end

endmodule

// File: rtl/seg_reseed_ctrl.sv
module seg_reseed_ctrl
  import srw_pkg::*;
#(
  parameter int               LFSR_W    = 16,
  parameter int               CHAINS    = 4,
  parameter int               CHAIN_LEN = 8,
  parameter int               SEGS      = 4,
  parameter int               VPS       = 2,
  parameter logic [LFSR_W-1:0] TAPS     = 16'hB400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              seed_valid,
  input  logic [LFSR_W-1:0] seed_data,
  input  logic              seed_step,
  input  logic              seed_last,
  output logic              seed_req,
  output logic [CHAINS-1:0] scan_in,
  output logic              scan_en,
  output logic              capture,
  output logic              done
);

  localparam int SEG_W = $clog2(SEGS + 1);

  ctrl_state_t       state_q, state_d;
  logic              last_q;
  logic [LFSR_W-1:0] lfsr_q;
  logic [SEG_W-1:0]  budget_q, budget_d, seg_cnt;

  // Named internal events
  logic seed_take, run_init, bit_last, vec_last, win_last;

  assign seed_take = (state_q == ST_REQ) && seed_valid;
  assign run_init  = start && (state_q == ST_IDLE || state_q == ST_DONE);

  srw_lfsr #(.W(LFSR_W), .TAPS(TAPS)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .load(seed_take), .step(state_q == ST_SHIFT),
    .seed(seed_data), .state(lfsr_q)
  );

  srw_budget #(.SEGS(SEGS), .SEG_W(SEG_W)) u_budget (
    .clk(clk), .rst_n(rst_n), .init(run_init), .take(seed_take), .step(seed_step),
    .count(budget_q), .next_count(budget_d)
  );

  srw_window_seq #(.CHAIN_LEN(CHAIN_LEN), .VPS(VPS), .SEGS(SEGS), .SEG_W(SEG_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .load(seed_take), .load_segs(budget_d),
    .shifting(state_q == ST_SHIFT), .capturing(state_q == ST_CAPT),
    .bit_last(bit_last), .vec_last(vec_last), .win_last(win_last), .seg_cnt(seg_cnt)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start)     state_d = ST_REQ;
      ST_REQ:   if (seed_take) state_d = ST_SHIFT;
      ST_SHIFT: if (bit_last)  state_d = ST_CAPT;
      ST_CAPT:  state_d = win_last ? (last_q ? ST_DONE : ST_REQ) : ST_SHIFT;
      ST_DONE:  if (start)     state_d = ST_REQ;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      last_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (seed_take) last_q <= seed_last;
    end
  end

  assign seed_req = (state_q == ST_REQ);
  assign scan_en  = (state_q == ST_SHIFT);
  assign capture  = (state_q == ST_CAPT);
  assign done     = (state_q == ST_DONE);
  assign scan_in  = lfsr_q[CHAINS-1:0];

endmodule

// File: rtl/srw_checker.sv
module srw_checker #(
  parameter int SEGS  = 4,
  parameter int SEG_W = $clog2(SEGS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             seed_valid,
  input logic             seed_req,
  input logic             scan_en,
  input logic             capture,
  input logic             done,
  input logic             seed_take,
  input logic [SEG_W-1:0] budget_q,
  input logic [SEG_W-1:0] seg_cnt
);

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_req && !seed_valid) |=> seed_req);

  assert_capture_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> !capture);

  assert_capture_after_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(capture) |-> $past(scan_en));

  assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(scan_en && capture));

  assert_budget_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (budget_q >= SEG_W'(1)) && (budget_q <= SEG_W'(SEGS)));

  assert_budget_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    seed_take |=> (($past(budget_q) - budget_q) <= SEG_W'(1)));

  assert_seg_within_budget_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en || capture) |-> (seg_cnt <= budget_q));

  assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

endmodule

bind seg_reseed_ctrl srw_checker #(.SEGS(SEGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .seed_valid(seed_valid),
  .seed_req(seed_req), .scan_en(scan_en), .capture(capture), .done(done),
  .seed_take(seed_take), .budget_q(budget_q), .seg_cnt(seg_cnt)
);

// File: tb/seg_reseed_ctrl_test.sv
module seg_reseed_ctrl_test;

  localparam int          CLK_PERIOD = 10;
  localparam int          W   = 16;
  localparam int          CH  = 4;
  localparam int          CL  = 8;
  localparam int          SEGS = 4;
  localparam int          VPS = 2;
  localparam logic [15:0] TAPS = 16'hB400;

  logic          clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic          seed_valid = 1'b0, seed_step = 1'b0, seed_last = 1'b0;
  logic [W-1:0]  seed_data = '0;
  logic          seed_req, scan_en, capture, done;
  logic [CH-1:0] scan_in;

  int errors = 0, checks = 0, exp_k = SEGS;

  seg_reseed_ctrl #(.LFSR_W(W), .CHAINS(CH), .CHAIN_LEN(CL), .SEGS(SEGS), .VPS(VPS), .TAPS(TAPS)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .seed_valid(seed_valid), .seed_data(seed_data),
    .seed_step(seed_step), .seed_last(seed_last), .seed_req(seed_req), .scan_in(scan_in),
    .scan_en(scan_en), .capture(capture), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] model_step(input logic [15:0] s);
    logic fb = 1'b0;
    for (int i = 0; i < 16; i++) if (TAPS[i]) fb = fb ^ s[i];
    return {s[14:0], fb};
  endfunction

  task automatic check(input logic ok, input string req, input int actual, input int expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    exp_k = SEGS;
    check(seed_req === 1'b1 && done === 1'b0, "R1/R7 start gives seed_req", int'(seed_req), 1);
  endtask

  task automatic feed_seed(input logic [15:0] seed, input logic stp, input logic last,
                           input logic noise, input string tag);
    logic [15:0] m;
    int vecs = 0, shifts = 0, run = 0, bad_bits = 0, bad_runs = 0;
    while (!seed_req) @(negedge clk);
    repeat (2) @(negedge clk);
    check(seed_req === 1'b1 && scan_en === 1'b0, {"R2 request held ", tag}, int'(seed_req), 1);
    if (stp && exp_k > 1) exp_k = exp_k - 1;
    seed_valid = 1'b1; seed_data = seed; seed_step = stp; seed_last = last;
    @(negedge clk);
    if (noise) begin
      seed_data = ~seed; seed_step = 1'b1; seed_last = 1'b1;
    end else seed_valid = 1'b0;
    m = seed;
    while (!seed_req && !done) begin
      if (scan_en) begin
        if (scan_in !== m[CH-1:0]) bad_bits++;
        m = model_step(m); shifts++; run++;
      end
      if (capture) begin
        if (run != CL) bad_runs++;
        run = 0; vecs++;
      end
      @(negedge clk);
    end
    seed_valid = 1'b0;
    check(bad_bits == 0, {"R3 scan bits vs model ", tag}, bad_bits, 0);
    check(bad_runs == 0 && shifts == vecs * CL, {"R4 shift run length ", tag}, shifts, vecs * CL);
    check(vecs == exp_k * VPS, {"R5/R6 vectors in window ", tag}, vecs, exp_k * VPS);
    if (last) check(done === 1'b1 && seed_req === 1'b0, {"R7 done after last ", tag}, int'(done), 1);
    else      check(seed_req === 1'b1 && done === 1'b0, {"R7 next request ", tag}, int'(seed_req), 1);
  endtask

  task automatic test_reset();
    check(seed_req === 1'b0 && done === 1'b0 && scan_en === 1'b0 && capture === 1'b0,
          "R1 reset outputs", int'({seed_req, done, scan_en, capture}), 0);
  endtask

  task automatic test_single_seed();
    pulse_start();
    feed_seed(16'hACE1, 1'b0, 1'b1, 1'b0, "single");
  endtask

  task automatic test_done_hold();
    for (int i = 0; i < 3; i++) begin
      seed_valid = 1'b1;
      @(negedge clk);
    end
    seed_valid = 1'b0;
    check(done === 1'b1 && seed_req === 1'b0 && scan_en === 1'b0, "R2/R7 done ignores seed_valid",
          int'(done), 1);
  endtask

  task automatic test_mixed_stream();
    pulse_start();
    feed_seed(16'h1234, 1'b0, 1'b0, 1'b0, "mix0");
    feed_seed(16'h8001, 1'b1, 1'b0, 1'b1, "mix1 noise");
    feed_seed(16'hFFFF, 1'b0, 1'b0, 1'b0, "mix2");
    feed_seed(16'h5A5A, 1'b1, 1'b1, 1'b0, "mix3");
  endtask

  task automatic test_floor();
    pulse_start();
    feed_seed(16'h0F0F, 1'b1, 1'b0, 1'b0, "floor3");
    feed_seed(16'h3C3C, 1'b1, 1'b0, 1'b0, "floor2");
    feed_seed(16'h0001, 1'b1, 1'b0, 1'b0, "floor1");
    feed_seed(16'h7777, 1'b1, 1'b0, 1'b0, "floor1 hold");
    feed_seed(16'hBEEF, 1'b1, 1'b1, 1'b0, "floor1 last");
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_single_seed();
    test_done_hold();
    test_mixed_stream();
    test_floor();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule